// File: doc/BRIEF.md
# Root hub status change bitmap

This block builds the status-change bitmap that a root hub returns to its host-side driver. It watches a set of per-port status inputs (the three change bits held in each port's status/control register, the link state, port power and speed class) and decides, port by port, whether anything about that port needs attention. A port that needs attention is reported as a set bit in a packed bitmap whose lowest bit belongs to the hub itself and is always clear.

Two pieces of per-port history are not available in the port registers, so the block keeps them itself. The first is a sticky suspend-change flag, raised when a port that software marked as suspended is seen back in the active link state with power on, and lowered only by an explicit clear command. The second is a resume timer, armed when a USB 2.0 speed port starts resume signalling and counting down on an external tick; once it runs out the port is reported as changed.

The ports are visited one per clock cycle. The bitmap, its byte length and a nonzero flag are registered outputs that change only when a full pass over the ports completes.

Top module: `hub_change_map`

## Requirements
- R1: A port is reported as changed whenever any of its connect-change, enable-change or over-current-change inputs is high.
- R2: Zero-based port i is reported at bitmap bit i+1 (byte (i+1)/8, bit (i+1)%8); bit 0 and every bit above NUM_PORTS are always 0.
- R3: The byte length output equals (NUM_PORTS+8)/8 when at least one port is reported and 0 otherwise; the nonzero flag is high exactly when the bitmap is not all zero.
- R4: A suspend mark pulse arms a port; when an armed port shows link code 0 (active) with power on, its suspend-change flag is set and the arm is dropped, so a later return to code 0 without a new mark raises nothing.
- R5: The suspend-change flag keeps its value until a clear command for that port; when the raising condition and the clear arrive in the same cycle, the flag is set. A set flag reports the port as changed.
- R6: A USB 2.0 speed port entering link code 15 (resume) loads its timer with the resume_ticks input; the port is reported as changed once exactly that many tick pulses have been seen while it stays in code 15, and leaving code 15 cancels the timer. A port not flagged USB 2.0 arms no timer.
- R7: After reset the bitmap, length and nonzero flag are 0 and every per-port flag and timer is clear.
- R8: The outputs change only in the cycle after a full pass over all ports completes; a pass takes NUM_PORTS cycles, so a steady input shows up within 2*NUM_PORTS+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conn_chg | input | NUM_PORTS | Per-port connect-change bit |
| en_chg | input | NUM_PORTS | Per-port enable-change bit |
| oc_chg | input | NUM_PORTS | Per-port over-current-change bit |
| link_state | input | 4*NUM_PORTS | Per-port link state code, port i at bits 4i+3:4i |
| port_pwr | input | NUM_PORTS | Per-port power on |
| port_usb2 | input | NUM_PORTS | Per-port USB 2.0 speed class |
| tick | input | 1 | Timer tick pulse, one cycle wide |
| resume_ticks | input | TMR_W | Tick count loaded on resume entry |
| susp_mark | input | NUM_PORTS | Pulse: mark port as suspended |
| susp_chg_clr | input | NUM_PORTS | Pulse: clear port's suspend-change flag |
| chg_map | output | 8*((NUM_PORTS+8)/8) | Packed change bitmap |
| map_len | output | LEN_W | Bitmap length in bytes, 0 when nothing changed |
| map_nz | output | 1 | Bitmap has at least one bit set |

## Verification
The bench builds the block with eight ports and a 4-bit timer. Eight ports make the bitmap two bytes long, so the last port lands in the second byte and the length value 2 is exercised, while still letting the bench walk all 256 combinations of port change bits and compute each expected bitmap as a shift. The short timer lets the resume countdown be stepped one tick at a time to the exact expiry count.

// File: rtl/hcm_pkg.sv
package hcm_pkg;
    localparam logic [3:0] LINK_ACTIVE = 4'd0;
    localparam logic [3:0] LINK_SUSP   = 4'd3;
    localparam logic [3:0] LINK_RESUME = 4'd15;
endpackage

// File: rtl/hcm_port_track.sv
module hcm_port_track
    import hcm_pkg::*;
#(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       link,
    input  logic             pwr,
    input  logic             usb2,
    input  logic             tick,
    input  logic [TMR_W-1:0] resume_ticks,
    input  logic             mark,
    input  logic             clr,
    output logic             susp_chg,
    output logic             resume_due
);
    typedef struct packed {
        logic [3:0]       link;
        logic             armed;
        logic             schg;
        logic             pend;
        logic [TMR_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic wake, enter;

    always_comb begin
        st_d      = st_q;
        st_d.link = link;
        wake      = st_q.armed && (link == LINK_ACTIVE) && pwr;
        enter     = usb2 && (link == LINK_RESUME) && (st_q.link != LINK_RESUME);

        st_d.armed = mark || (st_q.armed && !wake);

        if (wake) begin
            st_d.schg = 1'b1;
        end else if (clr) begin
            st_d.schg = 1'b0;
        end

        if (link != LINK_RESUME) begin
            st_d.pend = 1'b0;
            st_d.cnt  = '0;
        end else if (enter) begin
            st_d.pend = 1'b1;
            st_d.cnt  = resume_ticks;
        end else if (st_q.pend && tick && (st_q.cnt != '0)) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign susp_chg   = st_q.schg;
    assign resume_due = st_q.pend && (st_q.cnt == '0);
endmodule

// File: rtl/hcm_scan.sv
module hcm_scan #(
    parameter int NUM_PORTS = 4,
    parameter int MAP_BYTES = (NUM_PORTS + 8) / 8,
    parameter int MAP_W     = 8 * MAP_BYTES,
    parameter int LEN_W     = $clog2(MAP_BYTES + 1),
    parameter int IDX_W     = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] chg,
    output logic [MAP_W-1:0]     map,
    output logic [LEN_W-1:0]     len,
    output logic                 nz,
    output logic                 wrap
);
    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [MAP_W-1:0] acc;
        logic [MAP_W-1:0] map;
        logic [LEN_W-1:0] len;
        logic             nz;
    } st_t;

    st_t st_d, st_q;
    logic [MAP_W-1:0] acc_nx;

    always_comb begin
        st_d   = st_q;
        wrap   = (st_q.idx == IDX_W'(NUM_PORTS - 1));
        acc_nx = st_q.acc | ({{(MAP_W-1){1'b0}}, chg[st_q.idx]} << (int'(st_q.idx) + 1));
        if (wrap) begin
            st_d.idx = '0;
            st_d.acc = '0;
            st_d.map = acc_nx;
            st_d.nz  = |acc_nx;
            st_d.len = (|acc_nx) ? LEN_W'(MAP_BYTES) : '0;
        end else begin
            st_d.idx = st_q.idx + 1'b1;
            st_d.acc = acc_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign map = st_q.map;
    assign len = st_q.len;
    assign nz  = st_q.nz;
endmodule

// File: rtl/hub_change_map.sv
module hub_change_map #(
    parameter int NUM_PORTS = 4,
    parameter int TMR_W     = 16,
    localparam int MAP_BYTES = (NUM_PORTS + 8) / 8,
    localparam int MAP_W     = 8 * MAP_BYTES,
    localparam int LEN_W     = $clog2(MAP_BYTES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_PORTS-1:0]   conn_chg,
    input  logic [NUM_PORTS-1:0]   en_chg,
    input  logic [NUM_PORTS-1:0]   oc_chg,
    input  logic [4*NUM_PORTS-1:0] link_state,
    input  logic [NUM_PORTS-1:0]   port_pwr,
    input  logic [NUM_PORTS-1:0]   port_usb2,
    input  logic                   tick,
    input  logic [TMR_W-1:0]       resume_ticks,
    input  logic [NUM_PORTS-1:0]   susp_mark,
    input  logic [NUM_PORTS-1:0]   susp_chg_clr,
    output logic [MAP_W-1:0]       chg_map,
    output logic [LEN_W-1:0]       map_len,
    output logic                   map_nz
);
    logic [NUM_PORTS-1:0] port_csc;
    logic [NUM_PORTS-1:0] port_due;
    logic [NUM_PORTS-1:0] port_chg;
    logic                 scan_wrap;

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
        hcm_port_track #(.TMR_W(TMR_W)) u_trk (
            .clk          (clk),
            .rst_n        (rst_n),
            .link         (link_state[4*i +: 4]),
            .pwr          (port_pwr[i]),
            .usb2         (port_usb2[i]),
            .tick         (tick),
            .resume_ticks (resume_ticks),
            .mark         (susp_mark[i]),
            .clr          (susp_chg_clr[i]),
            .susp_chg     (port_csc[i]),
            .resume_due   (port_due[i])
        );
    end

    always_comb begin
        port_chg = conn_chg | en_chg | oc_chg | port_csc | port_due;
    end

    hcm_scan #(.NUM_PORTS(NUM_PORTS)) u_scan (
        .clk   (clk),
        .rst_n (rst_n),
        .chg   (port_chg),
        .map   (chg_map),
        .len   (map_len),
        .nz    (map_nz),
        .wrap  (scan_wrap)
    );
endmodule

// File: rtl/hcm_chk.sv
module hcm_chk #(
    parameter int NUM_PORTS = 4,
    parameter int MAP_W     = 8,
    parameter int LEN_W     = 2,
    parameter int MAP_BYTES = 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [MAP_W-1:0]     chg_map,
    input logic [LEN_W-1:0]     map_len,
    input logic                 map_nz,
    input logic [NUM_PORTS-1:0] port_csc,
    input logic [NUM_PORTS-1:0] susp_chg_clr,
    input logic                 scan_wrap
);
    // R2
    hub_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_map[0] == 1'b0) && ((chg_map >> (NUM_PORTS + 1)) == '0));

    // R3
    len_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        map_nz ? (map_len == LEN_W'(MAP_BYTES)) : (map_len == '0));

    // R3
    nz_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        map_nz == (chg_map != '0));

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_wrap |=> ($stable(chg_map) && $stable(map_len) && $stable(map_nz)));

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_c
        // R5
        csc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (port_csc[i] && !susp_chg_clr[i]) |=> port_csc[i]);
    end
endmodule

bind hub_change_map hcm_chk #(
    .NUM_PORTS (NUM_PORTS),
    .MAP_W     (MAP_W),
    .LEN_W     (LEN_W),
    .MAP_BYTES (MAP_BYTES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .chg_map      (chg_map),
    .map_len      (map_len),
    .map_nz       (map_nz),
    .port_csc     (port_csc),
    .susp_chg_clr (susp_chg_clr),
    .scan_wrap    (scan_wrap)
);

// File: tb/tb_hub_change_map.sv
module tb_hub_change_map;
    localparam int N     = 8;
    localparam int TW    = 4;
    localparam int MB    = (N + 8) / 8;
    localparam int MW    = 8 * MB;
    localparam int LW    = $clog2(MB + 1);
    localparam int SETTLE = 2 * N + 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    conn_chg = '0, en_chg = '0, oc_chg = '0;
    logic [4*N-1:0]  link_state = '0;
    logic [N-1:0]    port_pwr = '0, port_usb2 = '0;
    logic            tick = 1'b0;
    logic [TW-1:0]   resume_ticks = '0;
    logic [N-1:0]    susp_mark = '0, susp_chg_clr = '0;
    logic [MW-1:0]   chg_map;
    logic [LW-1:0]   map_len;
    logic            map_nz;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    hub_change_map #(.NUM_PORTS(N), .TMR_W(TW)) dut (
        .clk(clk), .rst_n(rst_n), .conn_chg(conn_chg), .en_chg(en_chg), .oc_chg(oc_chg),
        .link_state(link_state), .port_pwr(port_pwr), .port_usb2(port_usb2), .tick(tick),
        .resume_ticks(resume_ticks), .susp_mark(susp_mark), .susp_chg_clr(susp_chg_clr),
        .chg_map(chg_map), .map_len(map_len), .map_nz(map_nz)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual cyc=%0d expected completion", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic settle();
        repeat (SETTLE) @(posedge clk);
        #1;
    endtask

    task automatic cyc1();
        @(negedge clk);
    endtask

    // expected map from a port mask: port i at bit i+1
    task automatic check_map(input string req, input logic [N-1:0] pm);
        logic [MW-1:0] em;
        logic [LW-1:0] el;
        em = MW'({pm, 1'b0});
        el = (pm != '0) ? LW'(MB) : '0;
        checks = checks + 1;
        if (chg_map !== em || map_len !== el || map_nz !== (pm != '0)) begin
            errors = errors + 1;
            $display("FAIL %s: actual map=%h len=%0d nz=%0b expected map=%h len=%0d nz=%0b",
                     req, chg_map, map_len, map_nz, em, el, (pm != '0));
        end
    endtask

    task automatic set_link(input int p, input logic [3:0] code);
        link_state[4*p +: 4] = code;
    endtask

    task automatic pulse_tick();
        cyc1(); tick = 1'b1;
        cyc1(); tick = 1'b0;
        repeat (2) cyc1();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R7 reset state
        check_map("R7", '0);
        @(negedge clk); rst_n = 1'b1;
        settle();
        check_map("R7", '0);

        // R1 R2: single change bit per port per source
        for (int p = 0; p < N; p++) begin
            for (int s = 0; s < 3; s++) begin
                @(negedge clk);
                conn_chg = '0; en_chg = '0; oc_chg = '0;
                if (s == 0) conn_chg[p] = 1'b1;
                if (s == 1) en_chg[p]   = 1'b1;
                if (s == 2) oc_chg[p]   = 1'b1;
                settle();
                check_map("R1", N'(1) << p);
            end
        end

        // R2 R3: every port mask, bits spread over the sources
        for (int m = 0; m < (1 << N); m++) begin
            @(negedge clk);
            conn_chg = N'(m) & N'(8'h55);
            en_chg   = N'(m) & N'(8'h22);
            oc_chg   = N'(m) & N'(8'h88);
            settle();
            check_map("R2", N'(m));
        end
        @(negedge clk);
        conn_chg = '0; en_chg = '0; oc_chg = '0;
        settle();
        check_map("R3", '0);

        // R8: output held between pass ends; change appears within the bound
        @(negedge clk);
        oc_chg[5] = 1'b1;
        repeat (2 * N + 1) @(posedge clk);
        #1;
        check_map("R8", N'(1) << 5);
        @(negedge clk);
        oc_chg[5] = 1'b0;
        settle();

        // R4: mark alone reports nothing
        port_pwr = '1;
        @(negedge clk); set_link(2, 4'd3); susp_mark[2] = 1'b1;
        @(negedge clk); susp_mark[2] = 1'b0;
        settle();
        check_map("R4", '0);
        // power off in active state: no change yet
        @(negedge clk); port_pwr[2] = 1'b0; set_link(2, 4'd0);
        settle();
        check_map("R4", '0);
        // power on: flag raised
        @(negedge clk); port_pwr[2] = 1'b1;
        settle();
        check_map("R4", N'(1) << 2);
        // R5: sticky across link moves
        @(negedge clk); set_link(2, 4'd3);
        settle();
        check_map("R5", N'(1) << 2);
        @(negedge clk); set_link(2, 4'd0);
        settle();
        check_map("R5", N'(1) << 2);
        // R5: clear command on another port has no effect
        @(negedge clk); susp_chg_clr[3] = 1'b1;
        @(negedge clk); susp_chg_clr[3] = 1'b0;
        settle();
        check_map("R5", N'(1) << 2);
        // R5: clear command for this port
        @(negedge clk); susp_chg_clr[2] = 1'b1;
        @(negedge clk); susp_chg_clr[2] = 1'b0;
        settle();
        check_map("R5", '0);
        // R4: arm dropped, second return to active without mark raises nothing
        @(negedge clk); set_link(2, 4'd3);
        repeat (3) cyc1();
        set_link(2, 4'd0);
        settle();
        check_map("R4", '0);
        // R5: raise and clear in the same cycle, set wins
        @(negedge clk); set_link(2, 4'd3); susp_mark[2] = 1'b1;
        @(negedge clk); susp_mark[2] = 1'b0;
        repeat (2) cyc1();
        set_link(2, 4'd0); susp_chg_clr[2] = 1'b1;
        @(negedge clk); susp_chg_clr[2] = 1'b0;
        settle();
        check_map("R5", N'(1) << 2);
        @(negedge clk); susp_chg_clr[2] = 1'b1;
        @(negedge clk); susp_chg_clr[2] = 1'b0;
        settle();
        check_map("R5", '0);

        // R6: resume timer on a USB 2.0 port
        resume_ticks = TW'(5);
        port_usb2[6] = 1'b1;
        @(negedge clk); set_link(6, 4'd15);
        repeat (3) cyc1();
        for (int t = 1; t <= 4; t++) pulse_tick();
        settle();
        check_map("R6", '0);
        pulse_tick();
        settle();
        check_map("R6", N'(1) << 6);
        // R6: leaving resume cancels
        @(negedge clk); set_link(6, 4'd0);
        settle();
        check_map("R6", '0);
        // R6: cancel midway, re-entry reloads the full count
        @(negedge clk); set_link(6, 4'd15);
        repeat (3) cyc1();
        for (int t = 1; t <= 3; t++) pulse_tick();
        set_link(6, 4'd0);
        repeat (3) cyc1();
        set_link(6, 4'd15);
        repeat (3) cyc1();
        for (int t = 1; t <= 3; t++) pulse_tick();
        settle();
        check_map("R6", '0);
        for (int t = 1; t <= 2; t++) pulse_tick();
        settle();
        check_map("R6", N'(1) << 6);
        @(negedge clk); set_link(6, 4'd0);
        settle();
        // R6: port without USB 2.0 class arms no timer
        @(negedge clk); set_link(1, 4'd15);
        repeat (3) cyc1();
        for (int t = 1; t <= 8; t++) pulse_tick();
        settle();
        check_map("R6", '0);
        @(negedge clk); set_link(1, 4'd0);

        // R1 R4 R6 combined sources on different ports
        @(negedge clk); conn_chg[0] = 1'b1;
        resume_ticks = TW'(1);
        port_usb2[7] = 1'b1; set_link(7, 4'd15);
        repeat (3) cyc1();
        pulse_tick();
        settle();
        check_map("R6", N'(8'h81));

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule